// File: doc/BRIEF.md
# Serial ADC Command Slave Engine

This block is the device-side digital front of a multi-channel 12-bit sampling converter. It watches an active-low chip select, a serial clock and a serial command input. All three are oversampled in a faster system clock domain. From the command it takes a start bit, a mode bit and a three-bit channel field, and reports them on parallel configuration outputs. It then drives a sample-window strobe for the external converter model.

When the window closes, the block captures the converter's 12-bit parallel result. It then shifts out a low null bit, the result with the most significant bit first, and the same result again least significant bit first. The LSB-first word starts at B1, because B0 is shared between the two words. After that the output stays low for as long as clocks keep arriving.

The output changes only after falling serial clock edges, so a host can sample it on rising edges with the clock idling either low or high. Raising chip select ends a transfer at any point. The block accepts a transfer only after it has seen chip select high at least once since reset.

Top module: `adc_cmd_slave`

## Requirements
- R1: After reset the output enable, the data output and the sample strobe are low. If chip select has not been observed high since reset, no command is decoded and the output enable and strobe stay low.
- R2: With chip select low, zeros on the data input before the start bit are ignored. The start bit is the first rising serial clock edge that samples the data input high.
- R3: The first bit after the start bit appears on `cfg_single` (1 = single-ended, 0 = pseudo-differential). The next three bits form `cfg_chan`, with the first of them as its most significant bit. Both are valid once the fourth rising edge after the start bit has been seen.
- R4: Falling edges are numbered from 0, where edge 0 is the falling edge of the start-bit clock. `sample_win` rises after the fourth rising edge after the start bit and falls after falling edge 5.
- R5: The result is captured from `conv_result` when the window closes. Changes on `conv_result` after that point do not affect the bits sent.
- R6: `spi_miso_oe` is low up to and including falling edge 4. It goes high with `spi_miso` low (the null bit) after falling edge 5.
- R7: After falling edges 6 to 17, `spi_miso` carries result bits 11 down to 0.
- R8: After falling edges 18 to 28, `spi_miso` carries result bits 1 up to 11. After every later falling edge it is 0.
- R9: `spi_miso` changes only after a falling serial clock edge, or when chip select rises. It is unchanged across rising edges.
- R10: Raising chip select clears the output enable and the strobe within four system clocks. The next transfer is then decoded from scratch.
- R11: The full transfer works the same way with the serial clock idling high.
- R12: The data input during the clock after the last channel bit, and during all later clocks, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial command input |
| conv_result | input | RES_W | Parallel result from the converter model |
| spi_miso | output | 1 | Serial data output, low when not enabled |
| spi_miso_oe | output | 1 | Output enable; low means the output is released |
| sample_win | output | 1 | High while the converter should sample |
| cfg_single | output | 1 | Decoded mode bit |
| cfg_chan | output | CHAN_W | Decoded channel field |

## Verification
The bench builds the block with its defaults: a 12-bit result, a 3-bit channel field and two synchronizer stages. With these values the null bit falls on edge 5, the word boundaries fall on edges 17 and 28, and the trailing zeros start at edge 29, so every stretch of the output stream is visible within 34 serial clocks. Each serial clock phase lasts eight system clocks, which leaves room for the three-register path from pin to output before each sample. That spacing makes it possible to check the strobe on both sides of every edge and to abort a transfer in the middle.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

  typedef enum logic [1:0] {
    PH_STBY = 2'd0,
    PH_HUNT = 2'd1,
    PH_CMD  = 2'd2,
    PH_XFER = 2'd3
  } phase_e;

  // falling-edge slot carrying the null bit: mode bit + channel bits + one sampling clock
  function automatic int null_slot(input int chan_w);
    return chan_w + 2;
  endfunction

  // last slot that still carries a result bit (end of the LSB-first word)
  function automatic int last_slot(input int chan_w, input int res_w);
    return null_slot(chan_w) + 2 * res_w - 1;
  endfunction

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign lvl_o = stage_q[STAGES-1];

endmodule

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_cmd_pkg::*;
#(
  parameter int CHAN_W   = 3,
  parameter int CNT_W    = 5,
  parameter int NULL_IDX = 5,
  parameter int CNT_SAT  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              sclk_lvl,
  input  logic              sdi_lvl,
  output logic              win_o,
  output logic              single_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              shift_evt_o,
  output logic [CNT_W-1:0]  shift_idx_o
);

  localparam int CMD_BITS = 1 + CHAN_W;
  localparam int RCNT_W   = $clog2(CMD_BITS + 1);
  localparam logic [RCNT_W-1:0] LAST_CMD  = RCNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0]  NULL_CODE = CNT_W'(NULL_IDX);
  localparam logic [CNT_W-1:0]  SAT_CODE  = CNT_W'(CNT_SAT);

  phase_e              phase_q;
  logic                armed_q;
  logic                sclk_prev_q;
  logic [RCNT_W-1:0]   rcnt_q;
  logic [CNT_W-1:0]    fcnt_q;
  logic                win_q;
  logic                single_q;
  logic [CHAN_W-1:0]   chan_q;

  // named edge events
  logic sclk_rise, sclk_fall, in_frame;
  assign sclk_rise = sclk_lvl & ~sclk_prev_q;
  assign sclk_fall = ~sclk_lvl & sclk_prev_q;
  assign in_frame  = (phase_q == PH_CMD) || (phase_q == PH_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_STBY;
      armed_q  <= 1'b0;
      rcnt_q   <= '0;
      fcnt_q   <= '0;
      win_q    <= 1'b0;
      single_q <= 1'b0;
      chan_q   <= '0;
    end else if (cs_hi) begin
      phase_q <= PH_STBY;
      armed_q <= 1'b1;
      rcnt_q  <= '0;
      fcnt_q  <= '0;
      win_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_STBY: begin
          if (armed_q) phase_q <= PH_HUNT;
        end
        PH_HUNT: begin
          if (sclk_rise && sdi_lvl) begin
            phase_q <= PH_CMD;
            rcnt_q  <= '0;
            fcnt_q  <= '0;
          end
        end
        PH_CMD: begin
          if (sclk_rise) begin
            rcnt_q <= rcnt_q + 1'b1;
            if (rcnt_q == '0) single_q <= sdi_lvl;
            else              chan_q   <= {chan_q[CHAN_W-2:0], sdi_lvl};
            if (rcnt_q == LAST_CMD) begin
              win_q   <= 1'b1;
              phase_q <= PH_XFER;
            end
          end
          if (sclk_fall && fcnt_q != SAT_CODE) fcnt_q <= fcnt_q + 1'b1;
        end
        PH_XFER: begin
          if (sclk_fall) begin
            if (fcnt_q != SAT_CODE) fcnt_q <= fcnt_q + 1'b1;
            if (fcnt_q == NULL_CODE) win_q <= 1'b0;
          end
        end
        default: phase_q <= PH_STBY;
      endcase
    end
  end

  assign win_o       = win_q;
  assign single_o    = single_q;
  assign chan_o      = chan_q;
  assign shift_evt_o = sclk_fall && in_frame && !cs_hi;
  assign shift_idx_o = fcnt_q;

  // R1
  armed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_STBY) |-> armed_q);

  // R4
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> $past(sclk_rise));

  // R4
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_q) |-> ($past(sclk_fall) || $past(cs_hi)));

endmodule

// File: rtl/adc_result_tx.sv
module adc_result_tx #(
  parameter int RES_W    = 12,
  parameter int CNT_W    = 5,
  parameter int NULL_IDX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_hi,
  input  logic             shift_evt,
  input  logic [CNT_W-1:0] shift_idx,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             oe_o
);

  localparam logic [CNT_W-1:0] NULL_CODE = CNT_W'(NULL_IDX);

  logic [RES_W-1:0] res_q;
  logic             sdo_q;
  logic             oe_q;

  // bit carried after falling edge n, given the captured result
  function automatic logic slot_bit(input int n, input logic [RES_W-1:0] r);
    logic [RES_W-1:0] sh;
    sh = '0;
    if (n > NULL_IDX && n <= NULL_IDX + RES_W)
      sh = r >> (NULL_IDX + RES_W - n);
    else if (n > NULL_IDX + RES_W && n < NULL_IDX + 2 * RES_W)
      sh = r >> (n - NULL_IDX - RES_W);
    return sh[0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (cs_hi) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (shift_evt) begin
      if (shift_idx == NULL_CODE) begin
        res_q <= result_i;
        oe_q  <= 1'b1;
        sdo_q <= 1'b0;
      end else if (shift_idx > NULL_CODE) begin
        sdo_q <= slot_bit(int'(shift_idx), res_q);
      end
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;

  // R9
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(shift_evt) && !$past(cs_hi)) |-> $stable(sdo_q));

  // R6
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !sdo_q);

  // R5
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_evt) |-> $stable(res_q));

endmodule

// File: rtl/adc_cmd_slave.sv
module adc_cmd_slave
  import adc_cmd_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int CHAN_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  input  logic [RES_W-1:0]  conv_result,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              sample_win,
  output logic              cfg_single,
  output logic [CHAN_W-1:0] cfg_chan
);

  localparam int NULL_IDX = null_slot(CHAN_W);
  localparam int LAST_IDX = last_slot(CHAN_W, RES_W);
  localparam int CNT_SAT  = LAST_IDX + 1;
  localparam int CNT_W    = $clog2(CNT_SAT + 1);

  logic [2:0]       pin_lvl;
  logic             cs_hi;
  logic             shift_evt;
  logic [CNT_W-1:0] shift_idx;

  adc_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({spi_mosi, spi_csn, spi_sclk}),
    .lvl_o (pin_lvl)
  );

  assign cs_hi = pin_lvl[1];

  adc_cmd_decode #(
    .CHAN_W   (CHAN_W),
    .CNT_W    (CNT_W),
    .NULL_IDX (NULL_IDX),
    .CNT_SAT  (CNT_SAT)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_hi       (cs_hi),
    .sclk_lvl    (pin_lvl[0]),
    .sdi_lvl     (pin_lvl[2]),
    .win_o       (sample_win),
    .single_o    (cfg_single),
    .chan_o      (cfg_chan),
    .shift_evt_o (shift_evt),
    .shift_idx_o (shift_idx)
  );

  adc_result_tx #(
    .RES_W    (RES_W),
    .CNT_W    (CNT_W),
    .NULL_IDX (NULL_IDX)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_hi     (cs_hi),
    .shift_evt (shift_evt),
    .shift_idx (shift_idx),
    .result_i  (conv_result),
    .sdo_o     (spi_miso),
    .oe_o      (spi_miso_oe)
  );

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_hi) && cs_hi |-> !spi_miso_oe && !sample_win);

endmodule

// File: tb/adc_cmd_slave_test.sv
`timescale 1ns/1ps
module adc_cmd_slave_test;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        csn = 1'b0;
  logic        mosi = 1'b0;
  logic [11:0] conv = '0;
  logic        miso, miso_oe, win, single;
  logic [2:0]  chan;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_cmd_slave uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (sclk),
    .spi_csn     (csn),
    .spi_mosi    (mosi),
    .conv_result (conv),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe),
    .sample_win  (win),
    .cfg_single  (single),
    .cfg_chan    (chan)
  );

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected output after falling edge n (edge 0 = fall of start-bit clock)
  function automatic logic exp_bit(input int n, input logic [11:0] r);
    int p;
    p = n - 6;
    if (p >= 0 && p < 12) return r[11 - p];
    p = n - 17;
    if (p >= 1 && p <= 11) return r[p];
    return 1'b0;
  endfunction

  function automatic string data_req(input int n);
    if (n <= 5) return "R6";
    if (n <= 17) return "R7";
    return "R8";
  endfunction

  task automatic tick(input bit cpol, input logic din,
                      output logic d_mid, output logic d, output logic oe,
                      output logic w_mid, output logic w_end);
    if (!cpol) begin
      mosi = din;
      wait_c(H);
      sclk = 1'b1;
      wait_c(H);
      w_mid = win; d_mid = miso;
      sclk = 1'b0;
      wait_c(H);
    end else begin
      sclk = 1'b0;
      wait_c(H);
      w_mid = win; d_mid = miso;
      mosi = din;
      wait_c(H);
      sclk = 1'b1;
      wait_c(H);
    end
    d = miso; oe = miso_oe; w_end = win;
  endtask

  task automatic open_frame(input bit cpol);
    csn = 1'b1;
    wait_c(6);
    sclk = cpol;
    wait_c(6);
    csn = 1'b0;
    wait_c(6);
  endtask

  task automatic close_frame();
    csn = 1'b1;
    wait_c(6);
  endtask

  // full transfer; dc = data input level on every clock after the channel bits
  task automatic run_xfer(input bit cpol, input int lead, input logic sgl,
                          input logic [2:0] ch, input logic [11:0] res,
                          input bit late_change, input logic dc, input string tag);
    logic dm, d, oe, wm, we, prev_d, din;
    int n;
    string rq;
    conv = res;
    open_frame(cpol);
    for (int i = 0; i < lead; i++) begin
      tick(cpol, 1'b0, dm, d, oe, wm, we);
      check(oe == 1'b0 && we == 1'b0, {"R2 lead ", tag}, int'(oe), 0);
    end
    prev_d = miso;
    for (int j = 0; j < 34; j++) begin
      case (j)
        0: din = 1'b1;
        1: din = sgl;
        2: din = ch[2];
        3: din = ch[1];
        4: din = ch[0];
        default: din = dc;
      endcase
      tick(cpol, din, dm, d, oe, wm, we);
      n = cpol ? j - 1 : j;
      rq = late_change ? "R5" : data_req(n);
      if (!cpol) begin
        check(wm == (j == 4 || j == 5), {"R4 after rise ", tag}, int'(wm), int'(j == 4 || j == 5));
        check(we == (j == 4), {"R4 after fall ", tag}, int'(we), int'(j == 4));
        if (j > 0) check(dm == prev_d, {"R9 rise stable ", tag}, int'(dm), int'(prev_d));
      end else begin
        check(wm == (j == 5), {"R11 R4 after fall ", tag}, int'(wm), int'(j == 5));
        check(we == (j == 4 || j == 5), {"R11 R4 after rise ", tag}, int'(we), int'(j == 4 || j == 5));
      end
      check(oe == (n >= 5), {rq, " oe ", tag}, int'(oe), int'(n >= 5));
      if (n >= 5) check(d == exp_bit(n, res), {rq, " data ", tag}, int'(d), int'(exp_bit(n, res)));
      if (j == 4 + cpol) begin
        check(single == sgl, {"R3 mode ", tag}, int'(single), int'(sgl));
        check(chan == ch, {"R3 chan ", tag}, int'(chan), int'(ch));
      end
      if (late_change && j == 8) conv = ~res;
      prev_d = d;
    end
    close_frame();
  endtask

  task automatic t_reset_and_unarmed();
    logic dm, d, oe, wm, we;
    bit any_oe, any_w;
    // chip select has been low since power-up
    check(miso_oe == 1'b0, "R1 reset oe", int'(miso_oe), 0);
    check(miso == 1'b0, "R1 reset data", int'(miso), 0);
    check(win == 1'b0, "R1 reset strobe", int'(win), 0);
    any_oe = 0; any_w = 0;
    for (int j = 0; j < 14; j++) begin
      tick(1'b0, (j < 2) ? 1'b1 : 1'b0, dm, d, oe, wm, we);
      any_oe |= oe; any_w |= wm | we;
    end
    check(!any_oe, "R1 unarmed oe", int'(any_oe), 0);
    check(!any_w, "R1 unarmed strobe", int'(any_w), 0);
  endtask

  task automatic t_basic();
    run_xfer(1'b0, 5, 1'b1, 3'b101, 12'hA5C, 1'b0, 1'b0, "basic");
  endtask

  task automatic t_pattern_dc();
    // data input held high after the channel bits (R12) and a walking pattern
    run_xfer(1'b0, 0, 1'b0, 3'b010, 12'h3E1, 1'b0, 1'b1, "R12 dc-high");
  endtask

  task automatic t_late_result();
    run_xfer(1'b0, 2, 1'b1, 3'b111, 12'h81F, 1'b1, 1'b0, "latch");
  endtask

  task automatic t_mode11();
    run_xfer(1'b1, 3, 1'b0, 3'b001, 12'hC36, 1'b0, 1'b1, "R11 idle-high");
    sclk = 1'b0;
    wait_c(4);
  endtask

  task automatic t_abort();
    logic dm, d, oe, wm, we;
    open_frame(1'b0);
    conv = 12'h5A5;
    for (int j = 0; j < 10; j++)
      tick(1'b0, (j == 0) ? 1'b1 : 1'b0, dm, d, oe, wm, we);
    check(miso_oe == 1'b1, "R10 pre-abort oe", int'(miso_oe), 1);
    csn = 1'b1;
    wait_c(4);
    check(miso_oe == 1'b0, "R10 abort oe", int'(miso_oe), 0);
    check(miso == 1'b0, "R10 abort data", int'(miso), 0);
    check(win == 1'b0, "R10 abort strobe", int'(win), 0);
    wait_c(6);
    run_xfer(1'b0, 1, 1'b1, 3'b011, 12'h0F0, 1'b0, 1'b0, "R10 after abort");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    wait_c(10);
    rst_n = 1'b1;
    wait_c(6);
    t_reset_and_unarmed();
    t_basic();
    t_pattern_dc();
    t_late_result();
    t_mode11();
    t_abort();
    finish_run();
  end

endmodule